// File: doc/BRIEF.md
# Reset Cause Controller

This block merges the reset requests of a processor subsystem into one core reset. Three causes can start a reset after power-up: the external reset pin, an expiry pulse from the watchdog and a request from the software reset instruction. Power-on itself is the fourth cause. Every reset holds the core for a fixed number of clocks after its last trigger. The block records which cause produced the latest reset in a status byte with one cause bit set.

The top bit of the status byte is a software-writable enable for a reset-out pin. When that bit is set, the pin goes low for the whole hold interval of a reset that came from inside the chip (watchdog or software). It never follows the external pin. The block also supplies the value the watchdog control register takes after a reset, which depends on whether the watchdog caused that reset.

The block owns its power-on reset synchronizer: `por_n` asserts asynchronously and releases through two flops. The external pin passes through a two-flop synchronizer before it takes effect.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While the synchronized external pin is low, the core is held in reset (`core_rst_n`=0) and `cause` bits 3:0 read 4'b0001. A pin change reaches the reset logic on the third rising edge after it is driven. The core leaves reset 17 edges after the first edge that samples the pin high again.
- R2: A `wdt_expire` pulse sampled while the core runs sets `core_rst_n` low from that edge for exactly HOLD_CYC (16) cycles, with `cause` bits 3:0 = 4'b0010.
- R3: A `sw_rst_req` pulse sampled while the core runs gives the same 16-cycle reset, with `cause` bits 3:0 = 4'b0100.
- R4: During power-on reset, `cause` reads 8'h08 (bit 3 = power-on) and `core_rst_n` is 0. After `por_n` rises, the core stays in reset for 17 rising edges and is released on the 18th.
- R5: `cause` bits 3:0 always hold exactly one 1, and bits 6:4 always read 0.
- R6: A write strobe `out_en_wr` while the core runs loads `out_en_wdata` into `cause` bit 7 at that edge. Bit 7 keeps its value through pin, watchdog and software resets, and only power-on clears it.
- R7: When `cause` bit 7 is 1, `rst_out_n` is low for exactly the hold interval of a watchdog or software reset (the same cycles `core_rst_n` is low). When bit 7 is 0, `rst_out_n` stays high.
- R8: An external-pin reset never drives `rst_out_n` low. A pin reset that arrives during an internal reset takes over: `rst_out_n` returns high and the cause becomes pin.
- R9: `wdt_ctrl_init` reads 8'hE6 when the latest reset came from the watchdog and 8'hE4 after any other reset.
- R10: Causes that arrive on the same edge are ranked pin over watchdog over software. Watchdog and software requests that arrive while the core is in reset are ignored and do not extend the hold.
- R11: Writes to `cause` bit 7 are ignored while the core is in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| sw_rst_req | input | 1 | Software reset instruction pulse |
| out_en_wr | input | 1 | Write strobe for the reset-out enable bit |
| out_en_wdata | input | 1 | Value written to the reset-out enable bit |
| core_rst_n | output | 1 | Processor reset, active low |
| rst_out_n | output | 1 | Reset-out pin, low during enabled internal resets |
| cause | output | 8 | Reset cause byte: bit 7 enable, bits 3:0 one-hot cause |
| wdt_ctrl_init | output | 8 | Reset value for the watchdog control register |

## Verification
Watchdog and software requests take effect on the sampling edge itself, so `core_rst_n`, `cause`, `rst_out_n` and `wdt_ctrl_init` are due one edge after the pulse is driven, and release is due 16 edges later. A pin change passes through two synchronizer flops and is due three edges after it is driven. A power-on release adds two synchronizer edges ahead of the 16-cycle count. The bench drives and samples on falling edges and steps an exact number of rising edges before each check. It checks the last cycle of each interval and the first cycle after it.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_WDT  = 2'd2,
    SRC_SW   = 2'd3
  } rst_src_e;

  localparam int CAUSE_PIN    = 0;
  localparam int CAUSE_WDT    = 1;
  localparam int CAUSE_SW     = 2;
  localparam int CAUSE_POR    = 3;
  localparam int CAUSE_OUT_EN = 7;
  localparam int CODE_W       = 4;

  localparam logic [7:0] WDC_AFTER_WDT = 8'hE6;
  localparam logic [7:0] WDC_OTHER     = 8'hE4;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rcc_hold_timer.sv
module rcc_hold_timer #(
  parameter int HOLD_CYC = 16,
  localparam int CW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic released,
  output logic ending
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = CW'(HOLD_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    rel_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(HOLD_CYC);
      rel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign released = rel_q;
  assign ending   = !load && (cnt_q == CW'(1));
endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
  import rcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rst_src_e   src,
  input  logic       en_wr,
  input  logic       en_wdata,
  output logic [7:0] cause,
  output logic [7:0] wdt_ctrl_init
);
  logic              en_q, en_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    en_d   = en_wr ? en_wdata : en_q;
    code_d = code_q;
    case (src)
      SRC_PIN: code_d = CODE_W'(1 << CAUSE_PIN);
      SRC_WDT: code_d = CODE_W'(1 << CAUSE_WDT);
      SRC_SW:  code_d = CODE_W'(1 << CAUSE_SW);
      default: code_d = code_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= CODE_W'(1 << CAUSE_POR);
    end else begin
      en_q   <= en_d;
      code_q <= code_d;
    end
  end

  assign cause         = {en_q, 3'b000, code_q};
  assign wdt_ctrl_init = code_q[CAUSE_WDT] ? WDC_AFTER_WDT : WDC_OTHER;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int HOLD_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_rst_n,
  input  logic       wdt_expire,
  input  logic       sw_rst_req,
  input  logic       out_en_wr,
  input  logic       out_en_wdata,
  output logic       core_rst_n,
  output logic       rst_out_n,
  output logic [7:0] cause,
  output logic [7:0] wdt_ctrl_init
);
  logic     rst_sync_n;
  logic     pin_s;
  logic     released;
  logic     ending;
  logic     internal_hit;
  logic     wr_ok;
  rst_src_e src;
  logic     int_q, int_d;
  logic     rout_q, rout_d;

  rcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .rst_n(por_n), .d(1'b1), .q(rst_sync_n)
  );

  rcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pin_rst_n), .q(pin_s)
  );

  // Arbitration: pin overrides everything; internal causes only while running.
  always_comb begin
    src = SRC_NONE;
    if (!pin_s)                    src = SRC_PIN;
    else if (released && wdt_expire) src = SRC_WDT;
    else if (released && sw_rst_req) src = SRC_SW;
    internal_hit = (src == SRC_WDT) || (src == SRC_SW);
    wr_ok        = out_en_wr && released && (src == SRC_NONE);
  end

  rcc_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(src != SRC_NONE),
    .released(released), .ending(ending)
  );

  rcc_cause_reg u_cause (
    .clk(clk), .rst_n(rst_sync_n), .src(src),
    .en_wr(wr_ok), .en_wdata(out_en_wdata),
    .cause(cause), .wdt_ctrl_init(wdt_ctrl_init)
  );

  always_comb begin
    int_d = int_q;
    if (internal_hit)        int_d = 1'b1;
    else if (src == SRC_PIN) int_d = 1'b0;
    else if (ending)         int_d = 1'b0;
    rout_d = !(int_d && cause[CAUSE_OUT_EN]);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      int_q  <= 1'b0;
      rout_q <= 1'b1;
    end else begin
      int_q  <= int_d;
      rout_q <= rout_d;
    end
  end

  assign core_rst_n = released;
  assign rst_out_n  = rout_q;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_s,
  input logic       wdt_expire,
  input logic       sw_rst_req,
  input logic       core_rst_n,
  input logic       rst_out_n,
  input logic [7:0] cause
);
  assert_cause_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cause[3:0]) == 1) && (cause[6:4] == 3'b000));

  assert_pin_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_s |=> (!core_rst_n && cause[0]));

  assert_wdt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && pin_s && wdt_expire) |=> (!core_rst_n && cause[1]));

  assert_sw_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && pin_s && !wdt_expire && sw_rst_req) |=> (!core_rst_n && cause[2]));

  assert_rout_internal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> (!core_rst_n && cause[7] && (cause[1] || cause[2])));

  assert_pin_no_rout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cause[0] |-> rst_out_n);

  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst_n && pin_s) |=> $stable(cause[3:0]));

  assert_wr_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |=> $stable(cause[7]));
endmodule

bind rst_cause_ctrl rcc_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pin_s(pin_s),
  .wdt_expire(wdt_expire), .sw_rst_req(sw_rst_req),
  .core_rst_n(core_rst_n), .rst_out_n(rst_out_n), .cause(cause)
);

// File: tb/rst_cause_ctrl_bench.sv
module rst_cause_ctrl_bench;
  logic       clk = 1'b0;
  logic       por_n, pin_rst_n, wdt_expire, sw_rst_req, out_en_wr, out_en_wdata;
  logic       core_rst_n, rst_out_n;
  logic [7:0] cause, wdt_ctrl_init;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_ctrl u_rst_cause_ctrl (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wdt_expire(wdt_expire),
    .sw_rst_req(sw_rst_req), .out_en_wr(out_en_wr), .out_en_wdata(out_en_wdata),
    .core_rst_n(core_rst_n), .rst_out_n(rst_out_n), .cause(cause),
    .wdt_ctrl_init(wdt_ctrl_init)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wdt();
    wdt_expire = 1'b1; step(1); wdt_expire = 1'b0;
  endtask

  task automatic pulse_sw();
    sw_rst_req = 1'b1; step(1); sw_rst_req = 1'b0;
  endtask

  task automatic write_en(input logic v);
    out_en_wr = 1'b1; out_en_wdata = v; step(1); out_en_wr = 1'b0;
  endtask

  task automatic t_por();
    por_n = 1'b0; #1;
    check("R4 cause in por", cause, 8'h08);
    check("R4 core in por", core_rst_n, 0);
    check("R7 rout in por", rst_out_n, 1);
    check("R9 wdc after por", wdt_ctrl_init, 8'hE4);
    check("R5 bits 6:4", cause[6:4], 0);
    step(2); por_n = 1'b1;
    step(17); check("R4 core held 17 edges", core_rst_n, 0);
    step(1);  check("R4 core released 18th edge", core_rst_n, 1);
  endtask

  task automatic t_write_en();
    write_en(1'b1); check("R6 bit7 set", cause, 8'h88);
    write_en(1'b0); check("R6 bit7 clear", cause, 8'h08);
    write_en(1'b1);
  endtask

  task automatic t_wdt_enabled();
    pulse_wdt();
    check("R2 core low", core_rst_n, 0);
    check("R2 cause", cause, 8'h82);
    check("R7 rout low", rst_out_n, 0);
    check("R9 wdc E6", wdt_ctrl_init, 8'hE6);
    step(15);
    check("R2 core low last cycle", core_rst_n, 0);
    check("R7 rout low last cycle", rst_out_n, 0);
    step(1);
    check("R2 core released", core_rst_n, 1);
    check("R7 rout released", rst_out_n, 1);
  endtask

  task automatic t_sw_disabled();
    write_en(1'b0);
    pulse_sw();
    check("R3 core low", core_rst_n, 0);
    check("R3 cause", cause, 8'h04);
    check("R9 wdc E4 after sw", wdt_ctrl_init, 8'hE4);
    check("R7 rout high when disabled", rst_out_n, 1);
    step(15); check("R3 core low last", core_rst_n, 0);
    step(1);  check("R3 core released", core_rst_n, 1);
    write_en(1'b1);
  endtask

  task automatic t_ignore_in_hold();
    pulse_wdt();
    step(2);
    pulse_sw();
    check("R10 sw ignored in hold", cause, 8'h82);
    write_en(1'b0);
    check("R11 write ignored in hold", cause[7], 1);
    check("R11 rout still low", rst_out_n, 0);
    step(11); check("R10 no extend last cycle", core_rst_n, 0);
    step(1);  check("R10 no extend release", core_rst_n, 1);
  endtask

  task automatic t_same_edge();
    wdt_expire = 1'b1; sw_rst_req = 1'b1; step(1);
    wdt_expire = 1'b0; sw_rst_req = 1'b0;
    check("R10 wdt over sw", cause, 8'h82);
    step(16); check("R10 released", core_rst_n, 1);
  endtask

  task automatic t_pin_over_wdt();
    pin_rst_n = 1'b0;
    step(2);
    check("R1 not yet synced", core_rst_n, 1);
    pulse_wdt();
    check("R10 pin over wdt", cause, 8'h81);
    check("R8 rout high on pin", rst_out_n, 1);
    check("R1 core low", core_rst_n, 0);
    check("R6 bit7 kept by pin", cause[7], 1);
    step(30); check("R1 held while low", core_rst_n, 0);
    pin_rst_n = 1'b1;
    step(17); check("R1 held after release", core_rst_n, 0);
    step(1);  check("R1 released", core_rst_n, 1);
  endtask

  task automatic t_pin_during_internal();
    pulse_sw();
    check("R7 rout low sw", rst_out_n, 0);
    check("R3 cause sw enabled", cause, 8'h84);
    step(2);
    pin_rst_n = 1'b0;
    step(3);
    check("R8 rout high after pin takeover", rst_out_n, 1);
    check("R8 cause pin", cause, 8'h81);
    pin_rst_n = 1'b1;
    step(18); check("R1 released after takeover", core_rst_n, 1);
  endtask

  task automatic t_por_clears();
    @(posedge clk); #1; por_n = 1'b0; #1;
    check("R6 por clears bit7", cause, 8'h08);
    step(2); por_n = 1'b1;
    step(18); check("R4 released again", core_rst_n, 1);
  endtask

  initial begin
    por_n = 1'b0; pin_rst_n = 1'b1; wdt_expire = 1'b0; sw_rst_req = 1'b0;
    out_en_wr = 1'b0; out_en_wdata = 1'b0;
    @(negedge clk);
    t_por();
    t_write_en();
    t_wdt_enabled();
    t_sw_disabled();
    t_ignore_in_hold();
    t_same_edge();
    t_pin_over_wdt();
    t_pin_during_internal();
    t_por_clears();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule